// File: doc/BRIEF.md
# Dynamic-Width External Bus Sequencer

This block turns single requests from a 16-bit processor-side port into strobe sequences on an external memory bus. The bus can be 8 or 16 bits wide. A static mode input selects the width. Each request is a read or write of a byte or a word. The sequencer drives a full byte address, a multiplexed row/column address for DRAM, chip select, byte-lane enables, row and column strobes, output enable and write enable. Write data goes out on a separate output bus with its own drive-enable, and read data comes in on an input bus.

Reads are always done at full word width. A byte read still fetches both bytes of the word, and the unwanted byte is dropped before the response. On a narrow bus a word read therefore takes two byte beats, even address first. On a wide bus any read takes one beat. Every beat lasts two clocks: one clock with the row strobe and the row part of the address, then one clock with the column strobes and the column part.

The processor side uses a valid/ready handshake. A new request is taken only when the sequencer is idle. A one-clock done pulse returns the read data.

Top module: `ext_bus_seq`

## Requirements
- R1: Every read fetches a whole word. In 16-bit mode a byte read asserts both column strobes. The response of a byte read carries the addressed byte in rsp_rdata[7:0] (odd address gives the upper lane) with zeros above it. A word request ignores req_addr[0].
- R2: In 8-bit mode every read takes two beats. The first beat has ext_addr[0]=0 and the second has ext_addr[0]=1. The even byte lands in bits 7:0 of the assembled word.
- R3: In 8-bit mode lane_hi_n and col_hi_n stay high on every cycle, and col_lo_n serves both even and odd bytes.
- R4: A byte write in 16-bit mode asserts only the column strobe of its lane: col_lo_n for an even address, col_hi_n for an odd one. Byte write data is taken from req_wdata[7:0] and appears on the addressed lane.
- R5: oe_n stays high for the whole of every write request.
- R6: Each beat has one row clock and then one column clock. In the row clock, row_stb_n is low, both column strobes are high and dram_ma equals ext_addr[19:10]. In the column clock, row_stb_n is still low, the addressed column strobes are low and dram_ma equals ext_addr[9:0].
- R7: In 16-bit mode every request takes one beat. rsp_done goes high in the third clock after the accepting edge, and in general in clock 2*beats+1.
- R8: ext_doe is high exactly when we_n is low.
- R9: rsp_done is a one-clock pulse. req_ready is high only while no bus cycle is in progress.
- R10: In 8-bit mode a word write takes two beats: req_wdata[7:0] goes to the even address, then req_wdata[15:8] to the odd address, both on ext_dout[7:0]. A byte write takes one beat at its own address.
- R11: While reset is asserted, cs_n, row_stb_n, both column strobes, oe_n and we_n are high, and ext_doe and rsp_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus8 | input | 1 | 1 selects the 8-bit external bus, 0 the 16-bit bus; static |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_addr | input | 2*COL_W | Byte address |
| req_wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| ext_addr | output | 2*COL_W | External byte address |
| dram_ma | output | COL_W | Multiplexed address, row then column |
| cs_n | output | 1 | Chip select |
| row_stb_n | output | 1 | Row strobe |
| col_lo_n | output | 1 | Column strobe, low lane |
| col_hi_n | output | 1 | Column strobe, high lane |
| lane_lo_n | output | 1 | Low byte-lane enable |
| lane_hi_n | output | 1 | High byte-lane enable |
| oe_n | output | 1 | Output enable for read cycles |
| we_n | output | 1 | Write enable |
| ext_dout | output | 16 | Write data toward the bus |
| ext_doe | output | 1 | Drive-enable for ext_dout |
| ext_din | input | 16 | Read data from the bus |

## Verification
The assertions assume that bus8 changes only while the sequencer is idle. They also assume that the request fields stay steady from the moment req_valid rises until the accepting edge. The bench meets both assumptions: it drives new request fields and a new width only one time step after a rising edge, and only when req_ready is high. It drops req_valid right after the accepting edge. The bench models the external memory as a 16-byte array, indexed by the low address bits, which answers combinationally from ext_addr. Address patterns with distinct upper bits exercise the row/column split.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int COL_W = 10,
  localparam int AW = 2 * COL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus8,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_done,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] ext_addr,
  output logic [COL_W-1:0] dram_ma,
  output logic          cs_n,
  output logic          row_stb_n,
  output logic          col_lo_n,
  output logic          col_hi_n,
  output logic          lane_lo_n,
  output logic          lane_hi_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [15:0]   ext_dout,
  output logic          ext_doe,
  input  logic [15:0]   ext_din
);

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_COL} st_t;

  st_t           st;
  logic          beat, wr_q, word_q, done_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   wd_q, rd_q;

  wire byte_wr = wr_q && !word_q;
  wire two     = bus8 && !byte_wr;
  wire last    = !two || beat;
  wire active  = st != S_IDLE;
  wire in_col  = st == S_COL;
  wire lo_en   = bus8 || !byte_wr || !addr_q[0];
  wire hi_en   = !bus8 && (!byte_wr || addr_q[0]);

  logic [AW-1:0] cur_a;
  always_comb begin
    if (bus8)
      cur_a = two ? {addr_q[AW-1:1], beat} : addr_q;
    else
      cur_a = byte_wr ? addr_q : {addr_q[AW-1:1], 1'b0};
  end

  wire [7:0] wbyte = (word_q && beat) ? wd_q[15:8] : wd_q[7:0];

  assign req_ready = !active;
  assign rsp_done  = done_q;
  assign rsp_rdata = word_q ? rd_q : {8'h00, addr_q[0] ? rd_q[15:8] : rd_q[7:0]};
  assign ext_addr  = cur_a;
  assign dram_ma   = !active ? '0 : (st == S_ROW) ? cur_a[AW-1:COL_W] : cur_a[COL_W-1:0];
  assign cs_n      = !active;
  assign row_stb_n = !active;
  assign col_lo_n  = !(in_col && lo_en);
  assign col_hi_n  = !(in_col && hi_en);
  assign lane_lo_n = !(active && lo_en);
  assign lane_hi_n = !(active && hi_en);
  assign oe_n      = !(active && !wr_q);
  assign we_n      = !(in_col && wr_q);
  assign ext_doe   = in_col && wr_q;
  assign ext_dout  = bus8 ? {8'h00, wbyte} : (word_q ? wd_q : {wd_q[7:0], wd_q[7:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      beat   <= 1'b0;
      wr_q   <= 1'b0;
      word_q <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_ROW;
          beat   <= 1'b0;
          wr_q   <= req_write;
          word_q <= req_word;
          addr_q <= req_addr;
          wd_q   <= req_wdata;
        end
        S_ROW: st <= S_COL;
        S_COL: begin
          if (!wr_q) begin
            if (!bus8)     rd_q       <= ext_din;
            else if (beat) rd_q[15:8] <= ext_din[7:0];
            else           rd_q[7:0]  <= ext_din[7:0];
          end
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st   <= S_ROW;
            beat <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic bus8,
  input logic req_ready,
  input logic rsp_done,
  input logic row_stb_n,
  input logic col_lo_n,
  input logic col_hi_n,
  input logic lane_hi_n,
  input logic oe_n,
  input logic we_n,
  input logic ext_doe
);

  p_narrow_hi_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus8 |-> (lane_hi_n && col_hi_n));

  p_no_oe_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  p_drive_with_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_doe == !we_n);

  p_row_before_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_stb_n) |-> (col_lo_n && col_hi_n));

  p_col_under_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_lo_n || !col_hi_n) |-> (!row_stb_n && $past(!row_stb_n)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !row_stb_n |-> !req_ready);

endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus8(bus8), .req_ready(req_ready),
  .rsp_done(rsp_done), .row_stb_n(row_stb_n), .col_lo_n(col_lo_n),
  .col_hi_n(col_hi_n), .lane_hi_n(lane_hi_n), .oe_n(oe_n), .we_n(we_n),
  .ext_doe(ext_doe)
);

// File: tb/sim_ext_bus_seq.sv
module sim_ext_bus_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, bus8, req_valid, req_ready, req_write, req_word;
  logic [19:0] req_addr, ext_addr;
  logic [15:0] req_wdata, rsp_rdata, ext_dout, ext_din;
  logic [9:0]  dram_ma;
  logic        rsp_done, cs_n, row_stb_n, col_lo_n, col_hi_n, lane_lo_n, lane_hi_n;
  logic        oe_n, we_n, ext_doe;

  ext_bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus8(bus8), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ext_addr(ext_addr), .dram_ma(dram_ma),
    .cs_n(cs_n), .row_stb_n(row_stb_n), .col_lo_n(col_lo_n), .col_hi_n(col_hi_n),
    .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n), .oe_n(oe_n), .we_n(we_n),
    .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din)
  );

  logic [7:0] dev [16];
  logic [7:0] ref_m [16];
  int nchk = 0, nfail = 0;

  always_comb begin
    if (bus8) ext_din = {8'h00, dev[ext_addr[3:0]]};
    else      ext_din = {dev[{ext_addr[3:1], 1'b1}], dev[{ext_addr[3:1], 1'b0}]};
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {bus8, write, word, addr[19:0], wdata[15:0]}
  localparam logic [38:0] VEC [13] = '{
    {1'b0, 1'b0, 1'b0, 20'h12345, 16'h0000},
    {1'b0, 1'b0, 1'b1, 20'h6A002, 16'h0000},
    {1'b0, 1'b1, 1'b0, 20'h3C107, 16'h00E7},
    {1'b0, 1'b1, 1'b0, 20'h3C106, 16'h0051},
    {1'b0, 1'b0, 1'b1, 20'h3C107, 16'h0000},
    {1'b0, 1'b1, 1'b1, 20'hF0F08, 16'hBEEF},
    {1'b1, 1'b0, 1'b1, 20'hF0F08, 16'h0000},
    {1'b1, 1'b0, 1'b0, 20'h0AB09, 16'h0000},
    {1'b1, 1'b1, 1'b0, 20'h5555B, 16'hFF33},
    {1'b1, 1'b1, 1'b1, 20'h7777C, 16'hCAFE},
    {1'b0, 1'b0, 1'b1, 20'h0000C, 16'h0000},
    {1'b1, 1'b0, 1'b0, 20'h8880A, 16'h0000},
    {1'b0, 1'b0, 1'b0, 20'h9990B, 16'h0000}
  };

  task automatic run(input bit b8, input bit wr, input bit wd, input logic [19:0] a, input logic [15:0] w);
    int exp_beats, beats, n;
    bit got_done, prev_row, bad_oe, bad_hi, bad_lane, bad_ras, bad_ma, bad_doe, bad_rdy, bad_seq;
    logic [15:0] exp_rd;
    bit elo, ehi;
    exp_beats = (b8 && !(wr && !wd)) ? 2 : 1;
    elo = b8 || !(wr && !wd) || !a[0];
    ehi = !b8 && (!(wr && !wd) || a[0]);
    if (wd) exp_rd = {ref_m[{a[3:1], 1'b1}], ref_m[{a[3:1], 1'b0}]};
    else    exp_rd = {8'h00, ref_m[a[3:0]]};
    beats = 0; got_done = 0; prev_row = 0;
    {bad_oe, bad_hi, bad_lane, bad_ras, bad_ma, bad_doe, bad_rdy, bad_seq} = '0;
    @(posedge clk) #1;
    bus8 = b8; req_write = wr; req_word = wd; req_addr = a; req_wdata = w; req_valid = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1, "R9 ready when idle", {31'd0, req_ready}, 1);
    @(posedge clk) #1 req_valid = 1'b0;
    for (n = 1; n <= 12; n++) begin
      @(negedge clk);
      if (rsp_done) begin got_done = 1; break; end
      if (wr && !oe_n) bad_oe = 1;
      if (b8 && (!lane_hi_n || !col_hi_n)) bad_hi = 1;
      if (ext_doe !== !we_n) bad_doe = 1;
      if (!row_stb_n && req_ready) bad_rdy = 1;
      if (ext_addr[19:1] !== a[19:1]) bad_ma = 1;
      if (!row_stb_n && col_lo_n && col_hi_n) begin
        if (dram_ma !== ext_addr[19:10]) bad_ma = 1;
        prev_row = 1;
      end else if (!col_lo_n || !col_hi_n) begin
        if (dram_ma !== ext_addr[9:0] || !prev_row || row_stb_n) bad_ras = 1;
        prev_row = 0;
        if ((!col_lo_n) != elo || (!col_hi_n) != ehi) bad_lane = 1;
        if (exp_beats == 2 && ext_addr[0] !== beats[0]) bad_seq = 1;
        if (exp_beats == 1 && b8 && ext_addr[0] !== a[0]) bad_seq = 1;
        beats++;
        if (!we_n) begin
          if (b8) dev[ext_addr[3:0]] = ext_dout[7:0];
          else begin
            if (!col_lo_n) dev[{ext_addr[3:1], 1'b0}] = ext_dout[7:0];
            if (!col_hi_n) dev[{ext_addr[3:1], 1'b1}] = ext_dout[15:8];
          end
        end
      end
    end
    check(got_done && n == 2*exp_beats+1, "R7 done latency", n, 2*exp_beats+1);
    check(beats == exp_beats, b8 ? "R2/R10 beat count" : "R7 one beat", beats, exp_beats);
    check(!bad_lane, wr ? "R4 lane strobes" : "R1 full word lanes", {elo, ehi}, {elo, ehi});
    check(!bad_seq, "R2 R10 beat address order", 0, 0);
    check(!bad_ras && !bad_ma, "R6 row then column", {bad_ras, bad_ma}, 0);
    if (wr) check(!bad_oe, "R5 oe_n high on write", bad_oe, 0);
    if (b8) check(!bad_hi, "R3 high lane idle", bad_hi, 0);
    check(!bad_doe, "R8 drive enable", bad_doe, 0);
    check(!bad_rdy, "R9 not ready while busy", bad_rdy, 0);
    if (!wr) check(rsp_rdata === exp_rd, "R1 R2 read data", rsp_rdata, exp_rd);
    @(negedge clk);
    check(rsp_done === 1'b0, "R9 done one clock", rsp_done, 0);
    if (wr) begin
      if (wd) begin
        ref_m[{a[3:1], 1'b0}] = w[7:0];
        ref_m[{a[3:1], 1'b1}] = w[15:8];
      end else ref_m[a[3:0]] = w[7:0];
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin dev[i] = 8'hA0 + 8'(i); ref_m[i] = 8'hA0 + 8'(i); end
    rst_n = 1'b0; bus8 = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check({cs_n, row_stb_n, col_lo_n, col_hi_n, oe_n, we_n} === 6'h3F && !ext_doe && !rsp_done,
          "R11 reset outputs", {cs_n, row_stb_n, col_lo_n, col_hi_n, oe_n, we_n, ext_doe, rsp_done}, 8'hFC);
    @(posedge clk) #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready === 1'b1 && cs_n === 1'b1, "R11 idle after reset", {req_ready, cs_n}, 2'b11);
    for (int v = 0; v < 13; v++)
      run(VEC[v][38], VEC[v][37], VEC[v][36], VEC[v][35:16], VEC[v][15:0]);
    // R10 corner: narrow byte write to even address, then wide word read of that word
    run(1'b1, 1'b1, 1'b0, 20'h2468E, 16'h7744);
    run(1'b0, 1'b0, 1'b1, 20'h2468E, 16'h0000);
    check(dev[4'hE] === 8'h44, "R10 byte write data from bits 7:0", dev[4'hE], 8'h44);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired R7 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule